// File: doc/BRIEF.md
# Supply Droop Test Sequencer

This block drives a supply-margining test. It tells an external regulator or DAC controller how deep a supply reduction to apply, and when. The output is a percent code plus a pulse-active strobe. The schedule has two nested sweeps. The outer sweep sets the pulse width, over 5, 10, 20, 30 and so on up to 100 ms. For each width, the inner sweep steps the reduction depth over 5, 10, 20, 30, 40 and 50 percent. Both sweeps start with an irregular first step of 5 and then move in steps of 10.

At every depth/width pair the block applies a fixed number of pulses. A pulse repeats once per period, where the period is the larger of a minimum period and the pulse width plus a recovery gap. All timing comes from a tick count per millisecond.

An external monitor watches the device under test and raises an anomaly input. When it does, the sequencer removes the droop in that same cycle and freezes. It keeps the pair that caused the fault visible and raises fail. If no anomaly arrives, it raises done once the last pair has finished.

Top module: `droop_sweep_seq`

## Requirements
- R1: After reset the outputs are: `pulse_on`=0, `droop_pct`=0, `done`=0, `fail`=0. The step code `step_pct` reads 5 and `width_ms` reads 5.
- R2: A `start` sampled high while the sequencer is not running begins the schedule. The first pair is depth 5 and width 5, and `pulse_on` is high in the first cycle after the sampling edge. A `start` sampled while running has no effect on the schedule.
- R3: Within one width, `step_pct` (unsigned binary percent) takes the values 5, 10, 20, 30, 40, 50 in that order. After 50 it returns to 5 and the width advances.
- R4: `width_ms` (unsigned binary milliseconds) takes the values 5, 10, 20, ..., 100 in that order. Each width gets a full depth sweep.
- R5: Each pulse period lasts max(MIN_PERIOD_MS, width+GAP_MS) ms, where one ms is TICKS_PER_MS cycles. With the defaults this is width+1 ms. `pulse_on` is high for the first width×TICKS_PER_MS cycles of the period and low for the rest.
- R6: Exactly PULSES_PER_STEP pulse periods are applied at each depth/width pair before the schedule moves on.
- R7: `droop_pct` equals `step_pct` while `pulse_on` is high. At all other times it is 0, including idle, done and halted.
- R8: An `anomaly` sampled high while running forces `pulse_on` and `droop_pct` to 0 in that same cycle. From the next cycle on, `fail`=1, and `step_pct` and `width_ms` hold the pair that was in use. This lasts until the next start.
- R9: In the cycle after the last cycle of the last pair (depth 50, width 100), `done`=1 and `pulse_on`=0. `step_pct` holds 50 and `width_ms` holds 100.
- R10: `anomaly` has no effect when the sequencer is not running. An `anomaly` during the final schedule cycle gives `fail`=1 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin the schedule from its first pair |
| anomaly | input | 1 | Fault report from the external monitor |
| droop_pct | output | PCT_W (6) | Commanded supply reduction in percent; 0 when no pulse |
| pulse_on | output | 1 | Droop pulse active |
| step_pct | output | PCT_W (6) | Depth of the current (or frozen) pair in percent |
| width_ms | output | MS_W (7) | Pulse width of the current (or frozen) pair in ms |
| done | output | 1 | Schedule completed without anomaly |
| fail | output | 1 | Halted on anomaly |

## Verification
The critical collision is an anomaly report in the same cycle as the schedule's final pulse-period end. In that cycle the sequencer could either complete or halt. The bench provokes it by raising `anomaly` on exactly the last cycle of the depth-50, width-100 pair. It then judges that `fail` rises, `done` stays low, and the frozen pair reads 50/100. A second overlap, a restart request arriving mid-run, is injected during the schedule. Every following cycle is then compared against an arithmetically generated schedule to show the request left no trace.

// File: rtl/droop_seq_pkg.sv
package droop_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_HALT = 2'd3
  } seq_state_e;

  // Both sweeps share one rule: first step 5, then 10 per index.
  function automatic int sweep_value(input int idx);
    return (idx == 0) ? 5 : 10 * idx;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/droop_ms_tick.sv
module droop_ms_tick #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run_en,
  output logic ms_tick
);
  import droop_seq_pkg::*;

  localparam int TW = bits_for(TICKS_PER_MS);
  localparam logic [TW-1:0] LAST = TW'(TICKS_PER_MS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_en = clr | run_en;
    cnt_d  = cnt_q;
    if (clr)         cnt_d = '0;
    else if (wrap)   cnt_d = '0;
    else             cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ms_tick = run_en & ~clr & wrap;

  assert_tick_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/droop_period_timer.sv
module droop_period_timer #(
  parameter int MS_W            = 7,
  parameter int PULSES_PER_STEP = 8,
  parameter int GAP_MS          = 1,
  parameter int MIN_PERIOD_MS   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ms_tick,
  input  logic [MS_W-1:0] width_ms,
  output logic            in_pulse,
  output logic            step_end
);
  import droop_seq_pkg::*;

  localparam int PC_W = bits_for(PULSES_PER_STEP);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSES_PER_STEP - 1);

  logic [MS_W-1:0] ms_q, ms_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [MS_W-1:0] period_ms;
  logic [MS_W-1:0] span_ms;
  logic            period_end;
  logic            ms_en, pc_en;

  // Period is the larger of the floor and pulse plus recovery gap.
  always_comb begin
    span_ms   = width_ms + MS_W'(GAP_MS);
    period_ms = (span_ms > MS_W'(MIN_PERIOD_MS)) ? span_ms : MS_W'(MIN_PERIOD_MS);
  end

  assign period_end = ms_tick && (ms_q == period_ms - MS_W'(1));
  assign step_end   = period_end && (pc_q == PC_LAST);
  assign in_pulse   = (ms_q < width_ms);

  always_comb begin
    ms_en = clr | ms_tick;
    ms_d  = ms_q;
    if (clr || period_end) ms_d = '0;
    else                   ms_d = ms_q + MS_W'(1);
  end

  always_comb begin
    pc_en = clr | period_end;
    pc_d  = pc_q;
    if (clr || step_end) pc_d = '0;
    else                 pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assert_ms_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < period_ms);

  assert_pulse_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !step_end && !clr) |=> (pc_q == $past(pc_q) + PC_W'(1)));

endmodule

// File: rtl/droop_sweep_ctrl.sv
module droop_sweep_ctrl #(
  parameter int DEPTH_STEPS = 6,
  parameter int WIDTH_STEPS = 11,
  parameter int DI_W        = 3,
  parameter int WI_W        = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      anomaly,
  input  logic                      step_end,
  output droop_seq_pkg::seq_state_e state,
  output logic [DI_W-1:0]           depth_idx,
  output logic [WI_W-1:0]           width_idx,
  output logic                      run_en,
  output logic                      clr
);
  import droop_seq_pkg::*;

  localparam logic [DI_W-1:0] D_LAST = DI_W'(DEPTH_STEPS - 1);
  localparam logic [WI_W-1:0] W_LAST = WI_W'(WIDTH_STEPS - 1);

  seq_state_e      state_q, state_d;
  logic [DI_W-1:0] di_q, di_d;
  logic [WI_W-1:0] wi_q, wi_d;
  logic            running;

  assign running = (state_q == ST_RUN);
  assign clr     = start & ~running;
  assign run_en  = running & ~anomaly;

  always_comb begin
    state_d = state_q;
    di_d    = di_q;
    wi_d    = wi_q;
    unique case (state_q)
      ST_RUN: begin
        if (anomaly) begin
          state_d = ST_HALT;
        end else if (step_end) begin
          if (di_q != D_LAST) begin
            di_d = di_q + DI_W'(1);
          end else if (wi_q != W_LAST) begin
            di_d = '0;
            wi_d = wi_q + WI_W'(1);
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      default: begin
        if (start) begin
          state_d = ST_RUN;
          di_d    = '0;
          wi_d    = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      di_q    <= '0;
      wi_q    <= '0;
    end else begin
      state_q <= state_d;
      di_q    <= di_d;
      wi_q    <= wi_d;
    end
  end

  assign state     = state_q;
  assign depth_idx = di_q;
  assign width_idx = wi_q;

  assert_anomaly_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && anomaly) |=> (state_q == ST_HALT));

  assert_halt_holds_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !start) |=> ($stable(di_q) && $stable(wi_q) && state_q == ST_HALT));

  assert_depth_moves_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !step_end) |=> ($stable(di_q) && $stable(wi_q)));

  assert_idle_ignores_anomaly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start && anomaly) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/droop_sweep_seq.sv
module droop_sweep_seq #(
  parameter int TICKS_PER_MS    = 1000,
  parameter int PULSES_PER_STEP = 8,
  parameter int DEPTH_STEPS     = 6,
  parameter int WIDTH_STEPS     = 11,
  parameter int GAP_MS          = 1,
  parameter int MIN_PERIOD_MS   = 1,
  localparam int MAX_PCT  = droop_seq_pkg::sweep_value(DEPTH_STEPS - 1),
  localparam int PCT_W    = droop_seq_pkg::bits_for(MAX_PCT + 1),
  localparam int MAX_WMS  = droop_seq_pkg::sweep_value(WIDTH_STEPS - 1),
  localparam int MAX_PER  = droop_seq_pkg::max_int(MAX_WMS + GAP_MS, MIN_PERIOD_MS),
  localparam int MS_W     = droop_seq_pkg::bits_for(MAX_PER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             anomaly,
  output logic [PCT_W-1:0] droop_pct,
  output logic             pulse_on,
  output logic [PCT_W-1:0] step_pct,
  output logic [MS_W-1:0]  width_ms,
  output logic             done,
  output logic             fail
);
  import droop_seq_pkg::*;

  localparam int DI_W = bits_for(DEPTH_STEPS);
  localparam int WI_W = bits_for(WIDTH_STEPS);

  // Reset: asserts at once, releases on the second clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_e      state;
  logic [DI_W-1:0] depth_idx;
  logic [WI_W-1:0] width_idx;
  logic            run_en, clr, ms_tick, in_pulse, step_end;

  droop_sweep_ctrl #(
    .DEPTH_STEPS (DEPTH_STEPS),
    .WIDTH_STEPS (WIDTH_STEPS),
    .DI_W        (DI_W),
    .WI_W        (WI_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .anomaly   (anomaly),
    .step_end  (step_end),
    .state     (state),
    .depth_idx (depth_idx),
    .width_idx (width_idx),
    .run_en    (run_en),
    .clr       (clr)
  );

  droop_ms_tick #(
    .TICKS_PER_MS (TICKS_PER_MS)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clr     (clr),
    .run_en  (run_en),
    .ms_tick (ms_tick)
  );

  assign step_pct = PCT_W'(sweep_value(int'(depth_idx)));
  assign width_ms = MS_W'(sweep_value(int'(width_idx)));

  droop_period_timer #(
    .MS_W            (MS_W),
    .PULSES_PER_STEP (PULSES_PER_STEP),
    .GAP_MS          (GAP_MS),
    .MIN_PERIOD_MS   (MIN_PERIOD_MS)
  ) u_period (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr      (clr),
    .ms_tick  (ms_tick),
    .width_ms (width_ms),
    .in_pulse (in_pulse),
    .step_end (step_end)
  );

  assign pulse_on  = (state == ST_RUN) && in_pulse && !anomaly;
  assign droop_pct = pulse_on ? step_pct : '0;
  assign done      = (state == ST_DONE);
  assign fail      = (state == ST_HALT);

  assert_quiet_outside_run_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done || fail) |-> (droop_pct == '0 && !pulse_on));

  assert_finish_raises_done_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (state == ST_RUN && step_end && !anomaly &&
     depth_idx == DI_W'(DEPTH_STEPS - 1) && width_idx == WI_W'(WIDTH_STEPS - 1))
    |=> (done && !fail));

endmodule

// File: tb/droop_sweep_seq_bench.sv
`timescale 1ns/1ps
module droop_sweep_seq_bench;

  localparam int TPM    = 2;
  localparam int PULSES = 2;
  localparam int NDEP   = 6;
  localparam int NWID   = 11;

  logic       clk = 1'b0;
  logic       rst_n, start, anomaly;
  logic [5:0] droop_pct, step_pct;
  logic [6:0] width_ms;
  logic       pulse_on, done, fail;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  droop_sweep_seq #(
    .TICKS_PER_MS    (TPM),
    .PULSES_PER_STEP (PULSES)
  ) u_droop_sweep_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .anomaly   (anomaly),
    .droop_pct (droop_pct),
    .pulse_on  (pulse_on),
    .step_pct  (step_pct),
    .width_ms  (width_ms),
    .done      (done),
    .fail      (fail)
  );

  function automatic int sv(input int idx);
    return (idx == 0) ? 5 : 10 * idx;
  endfunction

  task automatic chk(input string req, input bit ep, input int epct, input int estep,
                     input int ew, input bit ed, input bit ef);
    checks++;
    if (pulse_on !== ep || int'(droop_pct) != epct || int'(step_pct) != estep ||
        int'(width_ms) != ew || done !== ed || fail !== ef) begin
      errors++;
      $display("FAIL %s: got pulse=%0d pct=%0d step=%0d width=%0d done=%0d fail=%0d; expected pulse=%0d pct=%0d step=%0d width=%0d done=%0d fail=%0d",
               req, pulse_on, droop_pct, step_pct, width_ms, done, fail,
               ep, epct, estep, ew, ed, ef);
    end
  endtask

  // Walks the whole schedule cycle by cycle; raises anomaly at the named point.
  task automatic run_sched(input int aw, input int ad, input int ap, input int am, input int at);
    bit hit = 1'b0;
    int cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int wi = 0; wi < NWID; wi++)
      for (int di = 0; di < NDEP; di++)
        for (int p = 0; p < PULSES; p++)
          for (int m = 0; m < sv(wi) + 1; m++)
            for (int t = 0; t < TPM; t++) begin
              if (!hit) begin
                if (wi == aw && di == ad && p == ap && m == am && t == at) begin
                  anomaly = 1'b1;
                  #1;
                  chk("R8 same-cycle cutoff", 1'b0, 0, sv(di), sv(wi), 1'b0, 1'b0);
                  @(negedge clk);
                  anomaly = 1'b0;
                  chk("R8 halt latches pair", 1'b0, 0, sv(di), sv(wi), 1'b0, 1'b1);
                  hit = 1'b1;
                end else begin
                  bit on = (m < sv(wi));
                  chk((cyc == 0) ? "R2 first pulse" : "R3/R4/R5/R6/R7 schedule",
                      on, on ? sv(di) : 0, sv(di), sv(wi), 1'b0, 1'b0);
                  start = (cyc == 7);   // R2: start while running is ignored
                  cyc++;
                  @(negedge clk);
                end
              end
            end
    start = 1'b0;
    if (!hit) chk("R9 completion", 1'b0, 0, 50, 100, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; anomaly = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 1'b0, 0, 5, 5, 1'b0, 1'b0);

    anomaly = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 anomaly while idle", 1'b0, 0, 5, 5, 1'b0, 1'b0);
    anomaly = 1'b0;
    @(negedge clk);

    run_sched(-1, 0, 0, 0, 0);

    anomaly = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 anomaly after done", 1'b0, 0, 50, 100, 1'b1, 1'b0);
    anomaly = 1'b0;
    @(negedge clk);

    run_sched(1, 2, 1, 3, 1);
    repeat (5) @(negedge clk);
    chk("R8 halt held", 1'b0, 0, 20, 10, 1'b0, 1'b1);

    run_sched(NWID - 1, NDEP - 1, PULSES - 1, 100, TPM - 1);
    repeat (2) @(negedge clk);
    chk("R10 fail wins over done", 1'b0, 0, 50, 100, 1'b0, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule